// File: doc/BRIEF.md
# Phase-Slip Post Divider

This block divides a fast oscillator-rate clock by a programmable integer ratio. It also lets software retard the divided output one oscillator period at a time. In front of the divider sits a pulse-swallow stage. Each time the asynchronous slip request goes from low to high, that stage withholds exactly one oscillator pulse from the divider. The divider therefore stands still for that cycle, and every later output edge moves one oscillator period later. Repeating the request walks the output phase step by step until it lines up with an external reference.

All gating is done with a clock enable inside the oscillator domain. No derived clock is gated. The divided output keeps a nominal 50% duty cycle at odd ratios as well: a copy of the high phase, taken on the falling edge, stretches the high time by half an oscillator period.

A feedback tap is also provided as an enable pattern. It reports either the raw oscillator (all ones) or the divider's own advance enable, so the swallowed pulses show as zeros. A free-running count of advanced pulses lets the number of swallowed pulses be read at the ports.

Top module: `phase_slip_divider`

## Requirements
- R1: With no slip requests and a ratio N of 2 to 15, `div_tick` pulses for one cycle every N oscillator cycles, and `div_out` has a period of N oscillator cycles.
- R2: For even N, `div_out` is high for N/2 cycles. For odd N above 1, it is high for N/2 cycles plus one half cycle. Measured in half cycles, the high time is always N of a 2N period.
- R3: A ratio input of 1 gives a pass-through enable pattern: `div_out` is high on every cycle that a pulse reaches the divider and low on a swallowed cycle, and `div_tick` pulses every advanced cycle. A ratio input of 0 behaves as 1.
- R4: Each 0-to-1 transition of `slip_req` removes exactly one oscillator pulse. All later ticks move one cycle later, so the tick phase modulo N shifts by one.
- R5: Holding `slip_req` high for any length of time removes only one pulse.
- R6: Several transitions in quick succession each remove one pulse. A request that arrives while a swallow is pending is queued, not lost.
- R7: A new ratio is adopted only at the end of the current output period. The period in progress completes with the old ratio and the next period uses the new one.
- R8: With `fb_sel` = 0, `fb_en` is 1 on every cycle. With `fb_sel` = 1, `fb_en` is 0 for exactly one cycle per swallowed pulse, registered one cycle after the swallow.
- R9: `passed_count` increases by one for every oscillator pulse that reaches the divider and wraps at its width. Elapsed cycles minus its increase equals the number of swallowed pulses.
- R10: A synchronous active-high `rst` clears the divider state, the output level, the tick, the feedback tap, the pulse count and any pending swallows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| slip_req | input | 1 | Asynchronous phase-slip request; each rising transition swallows one pulse |
| ratio_in | input | RATIO_W (4) | Post-divide ratio, 1 to 15 (0 treated as 1), adopted at the period end |
| fb_sel | input | 1 | Feedback tap source: 0 raw oscillator, 1 swallowed divider input |
| div_out | output | 1 | Divided output level, about 50% duty |
| div_tick | output | 1 | One-cycle pulse at each output period end |
| fb_en | output | 1 | Feedback tap as an enable pattern |
| passed_count | output | CNT_W (16) | Count of pulses that reached the divider |

## Verification
Every ratio from 1 to 15 is swept with no slips, and both tick spacing and high/low time are measured at half-cycle resolution. This separates a correct odd-ratio correction from a divider that is merely right in frequency. Single slips, a long held-high request and a quick burst of three transitions are then applied at odd, even and unit ratios. The resulting tick phase shift and pulse-count deficit distinguish one-per-edge behaviour from level-sensitive swallowing and from lost requests. A ratio change issued just after a tick checks that the current period finishes with the old ratio, and both feedback selections are observed across a slip.

// File: rtl/phase_slip_pkg.sv
package phase_slip_pkg;
  // How the output level is shaped for the ratio currently in force
  typedef enum logic [1:0] {
    DUTY_EVEN = 2'd0,
    DUTY_ODD  = 2'd1,
    DUTY_PASS = 2'd2
  } duty_mode_e;
endpackage

// File: rtl/slip_request_sync.sv
module slip_request_sync #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic adv,
  output logic rise
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic             meta_q, sync_q, prev_q;
  logic [PEND_W-1:0] pend_q;

  assign rise = sync_q & ~prev_q;
  assign adv  = (pend_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= '0;
    end else begin
      meta_q <= req_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (rise && pend_q == '0)
        pend_q <= pend_q + 1'b1;
      else if (!rise && pend_q != '0)
        pend_q <= pend_q - 1'b1;
      else if (rise && pend_q == PEND_MAX)
        pend_q <= PEND_MAX;
    end
  end

  // R5: one transition yields one detected edge, never two in a row
  p_single_edge_r5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
  // R6: a pending swallow drains by exactly one per cycle when nothing new arrives
  p_pend_drain_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_q != '0 && !rise) |=> pend_q == $past(pend_q) - 1'b1);
  // R6: a request is never dropped: a new edge leaves something pending
  p_no_loss_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> pend_q != '0);
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider
  import phase_slip_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               pos_hi,
  output logic               tick,
  output duty_mode_e         mode
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] ratio_q, cnt_q, ratio_eff, ratio_n, cnt_n;
  logic               wrap, pos_hi_n;
  duty_mode_e         mode_n;

  assign ratio_eff = (ratio_in == '0) ? ONE : ratio_in;
  assign wrap      = adv && (cnt_q == ratio_q - ONE);

  always_comb begin
    ratio_n = wrap ? ratio_eff : ratio_q;
    if (!adv)     cnt_n = cnt_q;
    else if (wrap) cnt_n = '0;
    else           cnt_n = cnt_q + ONE;
    if (ratio_n == ONE) begin
      pos_hi_n = adv;
      mode_n   = DUTY_PASS;
    end else begin
      pos_hi_n = (cnt_n < (ratio_n >> 1));
      mode_n   = ratio_n[0] ? DUTY_ODD : DUTY_EVEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= ratio_eff;
      cnt_q   <= ratio_eff - ONE;
      pos_hi  <= 1'b0;
      tick    <= 1'b0;
      mode    <= DUTY_EVEN;
    end else begin
      ratio_q <= ratio_n;
      cnt_q   <= cnt_n;
      pos_hi  <= pos_hi_n;
      tick    <= wrap;
      mode    <= mode_n;
    end
  end

  // R1: the phase counter stays inside the active ratio
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q < ratio_q);
  // R4: a swallowed cycle freezes the divider
  p_hold_on_swallow_r4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q) && !tick);
  // R7: the ratio only changes at a terminal count
  p_ratio_at_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(ratio_q));
  // R3: in pass mode a swallowed cycle drops the output
  p_pass_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (ratio_q == ONE && !adv) |=> !pos_hi);
  // R10: reset leaves the output and tick low
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> !pos_hi && !tick);
endmodule

// File: rtl/duty_corrector.sv
module duty_corrector
  import phase_slip_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pos_hi,
  input  duty_mode_e mode,
  output logic       level
);
  logic half_q;

  // Falling-edge copy of the high phase supplies the extra half cycle
  always_ff @(negedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= pos_hi;
  end

  assign level = pos_hi | (half_q & (mode == DUTY_ODD));

  // R2: outside odd mode the half-cycle term never extends the output
  p_even_plain_r2: assert property (@(negedge clk) disable iff (rst)
    (mode != DUTY_ODD && !pos_hi) |-> !level);
endmodule

// File: rtl/phase_slip_divider.sv
module phase_slip_divider
  import phase_slip_pkg::*;
#(
  parameter int RATIO_W = 4,
  parameter int PEND_W  = 3,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slip_req,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               fb_sel,
  output logic               div_out,
  output logic               div_tick,
  output logic               fb_en,
  output logic [CNT_W-1:0]   passed_count
);
  logic       adv, rise, pos_hi;
  duty_mode_e mode;

  slip_request_sync #(.PEND_W(PEND_W)) u_sync (
    .clk(clk), .rst(rst), .req_async(slip_req), .adv(adv), .rise(rise)
  );

  ratio_divider #(.RATIO_W(RATIO_W)) u_div (
    .clk(clk), .rst(rst), .adv(adv), .ratio_in(ratio_in),
    .pos_hi(pos_hi), .tick(div_tick), .mode(mode)
  );

  duty_corrector u_duty (
    .clk(clk), .rst(rst), .pos_hi(pos_hi), .mode(mode), .level(div_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_en        <= 1'b0;
      passed_count <= '0;
    end else begin
      fb_en        <= fb_sel ? adv : 1'b1;
      passed_count <= passed_count + CNT_W'(adv);
    end
  end

  // R8: the raw tap never shows a gap
  p_fb_raw_r8: assert property (@(posedge clk) disable iff (rst)
    !fb_sel |=> fb_en);
  // R9: every advanced pulse is counted once
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    adv |=> passed_count == $past(passed_count) + 1'b1);
  // R4: an edge is swallowed one cycle later
  p_edge_swallows_r4: assert property (@(posedge clk) disable iff (rst)
    rise |=> !adv);
endmodule

// File: tb/phase_slip_divider_test.sv
module phase_slip_divider_test;
  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;

  logic        clk = 1'b0;
  logic        rst, slip_req, fb_sel;
  logic [3:0]  ratio_in;
  logic        div_out, div_tick, fb_en;
  logic [15:0] passed_count;
  int          cyc = 0;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  phase_slip_divider uut (
    .clk(clk), .rst(rst), .slip_req(slip_req), .ratio_in(ratio_in),
    .fb_sel(fb_sel), .div_out(div_out), .div_tick(div_tick),
    .fb_en(fb_en), .passed_count(passed_count)
  );

  always #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all samples and drives happen 3 time units after a rising edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic next_tick(output int c);
    c = -1;
    for (int i = 0; i < 100 && c < 0; i++) begin
      step(1);
      if (div_tick) c = cyc;
    end
  endtask

  // high and whole period of div_out, counted in half cycles
  task automatic measure(output int hi, output int per);
    logic prev;
    int   lo;
    hi = 0; lo = 0;
    for (int i = 0; i < 200; i++) begin
      prev = div_out;
      #(HALF);
      if (!prev && div_out) break;
    end
    for (int i = 0; i < 100 && div_out; i++) begin hi++; #(HALF); end
    for (int i = 0; i < 100 && !div_out; i++) begin lo++; #(HALF); end
    per = hi + lo;
    @(posedge clk);
    #3;
  endtask

  task automatic pulse_req(input int high_cycles, input int low_cycles);
    slip_req = 1'b1;
    step(high_cycles);
    slip_req = 1'b0;
    step(low_cycles);
  endtask

  function automatic int mod_n(input int v, input int n);
    return ((v % n) + n) % n;
  endfunction

  // apply swallow stimulus at ratio n; check phase shift and pulse deficit
  task automatic slip_case(input int n, input int expect_shift, input int kind, input string tag);
    int t0, t1, c0, c1;
    logic [15:0] p0, p1;
    ratio_in = 4'(n);
    step(40);
    next_tick(t0);
    c0 = cyc; p0 = passed_count;
    case (kind)
      0: pulse_req(4, 4);
      1: pulse_req(60, 4);
      default: for (int k = 0; k < 3; k++) pulse_req(2, 2);
    endcase
    step(20);
    c1 = cyc; p1 = passed_count;
    check({tag, " pulse deficit"}, (c1 - c0) - int'(16'(p1 - p0)), expect_shift);
    next_tick(t1);
    check({tag, " tick phase shift"}, mod_n(t1 - t0 - expect_shift, n), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, hi, per, zeros;
    rst = 1'b1; slip_req = 1'b0; fb_sel = 1'b0; ratio_in = 4'd4;
    repeat (3) @(posedge clk);
    #3;
    // R10: reset state at the ports
    check("R10 div_out", int'(div_out), 0);
    check("R10 div_tick", int'(div_tick), 0);
    check("R10 fb_en", int'(fb_en), 0);
    check("R10 passed_count", int'(passed_count), 0);
    rst = 1'b0;

    // R1 R2 R3: sweep every ratio with no slips
    for (int n = 1; n <= 15; n++) begin
      ratio_in = 4'(n);
      step(40);
      next_tick(t0);
      next_tick(t1);
      check($sformatf("R1 tick spacing N=%0d", n), t1 - t0, n);
      if (n > 1) begin
        measure(hi, per);
        check($sformatf("R1 period halves N=%0d", n), per, 2 * n);
        check($sformatf("R2 high halves N=%0d", n), hi, n);
      end else begin
        zeros = 0;
        for (int i = 0; i < 16; i++) begin
          if (!div_out) zeros++;
          #(HALF);
        end
        step(1);
        check("R3 pass-through high", zeros, 0);
      end
    end

    // R3: ratio 0 acts as 1
    ratio_in = 4'd0;
    step(40);
    next_tick(t0);
    next_tick(t1);
    check("R3 ratio zero spacing", t1 - t0, 1);

    // R3 R4: a slip at ratio 1 drops the output for exactly one cycle
    ratio_in = 4'd1;
    step(10);
    zeros = 0;
    slip_req = 1'b1;
    for (int i = 0; i < 12; i++) begin step(1); if (!div_out) zeros++; end
    slip_req = 1'b0;
    step(4);
    check("R3 pass-mode gap cycles", zeros, 1);

    // R4: single slips at odd and even ratios
    slip_case(3, 1, 0, "R4 N=3");
    slip_case(4, 1, 0, "R4 N=4");
    slip_case(7, 1, 0, "R4 N=7");
    // R5: a long held request swallows once
    slip_case(5, 1, 1, "R5 held N=5");
    // R6: three quick transitions swallow three
    slip_case(8, 3, 2, "R6 burst N=8");
    slip_case(11, 3, 2, "R6 burst N=11");

    // R7: ratio change lands after the current period
    ratio_in = 4'd6;
    step(40);
    next_tick(t0);
    ratio_in = 4'd3;
    next_tick(t1);
    next_tick(t2);
    check("R7 old period kept", t1 - t0, 6);
    check("R7 new period used", t2 - t1, 3);

    // R8: feedback tap source
    ratio_in = 4'd5;
    fb_sel = 1'b0;
    step(10);
    zeros = 0;
    slip_req = 1'b1;
    for (int i = 0; i < 10; i++) begin step(1); if (!fb_en) zeros++; end
    slip_req = 1'b0;
    step(4);
    check("R8 raw tap gaps", zeros, 0);
    fb_sel = 1'b1;
    step(4);
    zeros = 0;
    slip_req = 1'b1;
    for (int i = 0; i < 10; i++) begin step(1); if (!fb_en) zeros++; end
    slip_req = 1'b0;
    step(4);
    check("R8 swallowed tap gaps", zeros, 1);

    // R9: no slips, count tracks cycles
    begin
      logic [15:0] p0;
      int c0;
      p0 = passed_count; c0 = cyc;
      step(50);
      check("R9 count rate", int'(16'(passed_count - p0)), cyc - c0);
    end

    // R10: reset mid-run clears everything again
    slip_req = 1'b1;
    step(1);
    rst = 1'b1;
    step(2);
    check("R10 re-reset passed_count", int'(passed_count), 0);
    check("R10 re-reset div_out", int'(div_out), 0);
    rst = 1'b0;
    slip_req = 1'b0;
    step(6);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule